// File: doc/BRIEF.md
# Transmit Endpoint Control and Status Register

This block is the per-endpoint control and status word of a full-speed USB device controller. Software sees it as one 10-bit word, written with a strobe and a data word and read back at any time. The transaction engine drives the other side. It sends single-cycle pulses when an IN transaction completes correctly, when the host acknowledges an IN data packet, when an isochronous IN data packet has been sent, and when a SETUP token arrives. It also supplies the endpoint type.

The word mixes three write rules. The transfer-complete flag can only be cleared by software. The toggle bit and both status pairs invert wherever a 1 is written. The endpoint address is plain read/write. Hardware events update the flag, the toggle bit and the transmit status, and the endpoint type decides which event applies. An interrupt request follows the flag, gated by a global enable.

Word layout: [3:0] endpoint address, [5:4] transmit status, [6] transmit toggle, [7] transfer-complete flag, [9:8] receive status. Status codes are 00 disabled, 01 stall, 10 NAK, 11 valid. Endpoint type codes are 00 bulk, 01 control, 10 isochronous, 11 interrupt.

Top module: `ep_tx_status_reg`

## Requirements
- R1: After reset every field of the word is 0, so status is disabled and DATA0 is expected, and irq is low.
- R2: A pulse on ev_tx_ok sets the flag (bit 7) at the next clock edge. This holds even when a software write in the same cycle would clear it.
- R3: Only ev_tx_ok sets the flag. Pulses on ev_in_ack, ev_setup or ev_iso_sent alone leave it unchanged. Writing 0 to bit 7 clears the flag, and writing 1 to bit 7 leaves it unchanged.
- R4: On a bulk, control or interrupt endpoint, ev_in_ack inverts the toggle (bit 6) and ev_iso_sent has no effect on it.
- R5: On a control endpoint (type 01), ev_setup sets the toggle to 1. On any other type, ev_setup has no effect on the toggle.
- R6: On an isochronous endpoint (type 10), ev_iso_sent inverts the toggle and ev_in_ack has no effect on it.
- R7: Writing 1 to bit 6, 5, 4, 9 or 8 inverts that bit, and writing 0 leaves it unchanged. A hardware update of the toggle or of the transmit status in the same cycle replaces the software effect on that field.
- R8: On a non-isochronous endpoint, ev_tx_ok forces the transmit status (bits 5:4) to NAK (10). On an isochronous endpoint, hardware never changes the transmit status.
- R9: Every write loads bits 3:0 into the endpoint address.
- R10: irq is high exactly when the flag is 1 and irq_en is high, with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 10 | Software write word |
| ev_tx_ok | input | 1 | Correct IN or control transfer completed |
| ev_in_ack | input | 1 | Host ACK received after an IN data packet |
| ev_iso_sent | input | 1 | Isochronous IN data packet sent |
| ev_setup | input | 1 | SETUP token addressed to this endpoint |
| ep_type | input | 2 | Endpoint type code |
| irq_en | input | 1 | Global transfer-interrupt enable |
| rd_data | output | 10 | Current register word |
| irq | output | 1 | Interrupt request |

## Verification
The clashes that matter happen when a software write and a hardware event land on the same field in one cycle. Two cases stand out. One is a clear of the flag together with ev_tx_ok. The other is a software toggle of bit 6 or of bits 5:4 together with an ACK, isochronous-send or SETUP update. Directed cycles place each of these pairs on one edge. Random cycles then mix writes, all four events and all endpoint types, so such overlaps keep recurring. A bench model built from the requirements predicts the word and irq after every edge. Each field is compared on its own, so a wrong winner shows up under the requirement for that field.

// File: rtl/ep_tx_status_reg.sv
module ep_tx_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [9:0] wr_data,
  input  logic       ev_tx_ok,
  input  logic       ev_in_ack,
  input  logic       ev_iso_sent,
  input  logic       ev_setup,
  input  logic [1:0] ep_type,
  input  logic       irq_en,
  output logic [9:0] rd_data,
  output logic       irq
);
  localparam logic [1:0] TYPE_CTRL = 2'b01;
  localparam logic [1:0] TYPE_ISO  = 2'b10;
  localparam logic [1:0] ST_NAK    = 2'b10;

  logic       done_q, tog_q;
  logic [1:0] txst_q, rxst_q;
  logic [3:0] addr_q;

  wire is_iso   = (ep_type == TYPE_ISO);
  wire tog_set  = ev_setup && (ep_type == TYPE_CTRL);
  wire tog_flip = is_iso ? ev_iso_sent : ev_in_ack;
  wire st_force = ev_tx_ok && !is_iso;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      tog_q  <= 1'b0;
      txst_q <= 2'b00;
      rxst_q <= 2'b00;
      addr_q <= 4'h0;
    end else begin
      if (ev_tx_ok)                   done_q <= 1'b1;
      else if (wr_en && !wr_data[7])  done_q <= 1'b0;

      if (tog_set)                    tog_q <= 1'b1;
      else if (tog_flip)              tog_q <= ~tog_q;
      else if (wr_en && wr_data[6])   tog_q <= ~tog_q;

      if (st_force)                   txst_q <= ST_NAK;
      else if (wr_en)                 txst_q <= txst_q ^ wr_data[5:4];

      if (wr_en) begin
        rxst_q <= rxst_q ^ wr_data[9:8];
        addr_q <= wr_data[3:0];
      end
    end
  end

  assign rd_data = {rxst_q, done_q, tog_q, txst_q, addr_q};
  assign irq     = done_q & irq_en;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) ev_tx_ok |=> rd_data[7]); // R2
  AST_FLAG_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n) (!ev_tx_ok && !rd_data[7]) |=> !rd_data[7]); // R3
  AST_ACK_FLIP: assert property (@(posedge clk) disable iff (!rst_n) (ev_in_ack && !ev_setup && ep_type != TYPE_ISO) |=> rd_data[6] != $past(rd_data[6])); // R4
  AST_SETUP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (ev_setup && ep_type == TYPE_CTRL) |=> rd_data[6]); // R5
  AST_ISO_FLIP: assert property (@(posedge clk) disable iff (!rst_n) (ev_iso_sent && ep_type == TYPE_ISO) |=> rd_data[6] != $past(rd_data[6])); // R6
  AST_NAK_FORCE: assert property (@(posedge clk) disable iff (!rst_n) (ev_tx_ok && ep_type != TYPE_ISO) |=> rd_data[5:4] == ST_NAK); // R8
  AST_ISO_STAT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (ep_type == TYPE_ISO && !wr_en) |=> $stable(rd_data[5:4])); // R8
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> rd_data[3:0] == $past(wr_data[3:0])); // R9
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n) !irq_en |-> !irq); // R10
endmodule

// File: tb/ep_tx_status_reg_test.sv
`timescale 1ns/1ps
module ep_tx_status_reg_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [9:0] wr_data = 0;
  logic       ev_tx_ok = 0, ev_in_ack = 0, ev_iso_sent = 0, ev_setup = 0;
  logic [1:0] ep_type = 0;
  logic       irq_en = 0;
  logic [9:0] rd_data;
  logic       irq;

  int n_run = 0, n_fail = 0;
  logic [9:0] model = 0;

  always #2.5 clk = ~clk;

  ep_tx_status_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ev_tx_ok(ev_tx_ok), .ev_in_ack(ev_in_ack), .ev_iso_sent(ev_iso_sent),
    .ev_setup(ev_setup), .ep_type(ep_type), .irq_en(irq_en),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [9:0] predict(logic [9:0] s, logic w, logic [9:0] d,
      logic ok, logic ack, logic iso_s, logic setup, logic [1:0] t);
    logic [9:0] n = s;
    if (ok) n[7] = 1'b1;
    else if (w && !d[7]) n[7] = 1'b0;
    if (setup && t == 2'b01) n[6] = 1'b1;
    else if ((t == 2'b10) ? iso_s : ack) n[6] = ~s[6];
    else if (w && d[6]) n[6] = ~s[6];
    if (ok && t != 2'b10) n[5:4] = 2'b10;
    else if (w) n[5:4] = s[5:4] ^ d[5:4];
    if (w) begin
      n[9:8] = s[9:8] ^ d[9:8];
      n[3:0] = d[3:0];
    end
    return n;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic w, logic [9:0] d, logic ok, logic ack, logic iso_s,
      logic setup, logic [1:0] t, logic ie);
    wr_en = w; wr_data = d; ev_tx_ok = ok; ev_in_ack = ack;
    ev_iso_sent = iso_s; ev_setup = setup; ep_type = t; irq_en = ie;
    model = predict(model, w, d, ok, ack, iso_s, setup, t);
    @(posedge clk);
    #1;
    wr_en = 0; ev_tx_ok = 0; ev_in_ack = 0; ev_iso_sent = 0; ev_setup = 0;
    check("R3 flag", 32'(rd_data[7]), 32'(model[7]));
    check("R4 toggle", 32'(rd_data[6]), 32'(model[6]));
    check("R8 tx status", 32'(rd_data[5:4]), 32'(model[5:4]));
    check("R7 rx status", 32'(rd_data[9:8]), 32'(model[9:8]));
    check("R9 address", 32'(rd_data[3:0]), 32'(model[3:0]));
    check("R10 irq", 32'(irq), 32'(model[7] & ie));
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset word", 32'(rd_data), 32'h0);
    check("R1 reset irq", 32'(irq), 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R3: other events alone do not set the flag
    step(0, 0, 0, 1, 1, 1, 2'b01, 1);
    check("R3 no set", 32'(rd_data[7]), 32'h0);
    // R2: set wins over same-cycle clear
    step(1, 10'h000, 1, 0, 0, 0, 2'b00, 1);
    check("R2 set over clear", 32'(rd_data[7]), 32'h1);
    // R8: NAK forced on bulk
    check("R8 nak", 32'(rd_data[5:4]), 32'h2);
    // R3: write 1 keeps, write 0 clears
    step(1, 10'h080, 0, 0, 0, 0, 2'b00, 0);
    check("R3 keep", 32'(rd_data[7]), 32'h1);
    step(1, 10'h000, 0, 0, 0, 0, 2'b00, 0);
    check("R3 clear", 32'(rd_data[7]), 32'h0);
    // R7: ACK flip wins over software toggle
    step(1, 10'h040, 0, 1, 0, 0, 2'b00, 0);
    // R5: SETUP on control forces 1, on bulk ignored
    step(1, 10'h040, 0, 0, 0, 0, 2'b00, 0);
    step(0, 0, 0, 0, 0, 1, 2'b01, 0);
    check("R5 setup one", 32'(rd_data[6]), 32'h1);
    step(0, 0, 0, 0, 0, 1, 2'b00, 0);
    check("R5 setup ignored", 32'(rd_data[6]), 32'h1);
    // R6: iso flip, iso status held on ev_tx_ok
    step(1, 10'h330, 0, 0, 0, 0, 2'b10, 0);
    step(0, 0, 1, 1, 1, 0, 2'b10, 1);
    check("R6 iso flip", 32'(rd_data[6]), 32'h0);
    check("R8 iso held", 32'(rd_data[5:4]), 32'(model[5:4]));

    for (int i = 0; i < 2000; i++) begin
      logic w;
      w = ($urandom % 3) == 0;
      step(w, 10'($urandom), ($urandom % 5) == 0, ($urandom % 4) == 0,
           ($urandom % 4) == 0, ($urandom % 6) == 0, 2'($urandom), 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule